// File: doc/BRIEF.md
# I2C Master Address-Phase Controller

This block is the master side of a two-wire serial bus. It covers only the opening of a transfer. It issues the start condition and shifts out a 7-bit target address together with a read/write flag. It then clocks a ninth cycle in which the addressed target may pull the data line low to acknowledge. Both bus lines are open-drain. The block only ever pulls a line low, through an enable output, and it reads the resolved line levels back on its inputs.

Software sets up the block through three byte-wide registers: a control register, an address/data buffer and a configuration register. The four upper bits of a control write form a command. The block reports its state on flag outputs: master mode, transmit direction, bus busy, pending-service, and the last received bit. After the address byte it raises a one-cycle interrupt and clears the pending flag. It then keeps the clock line low until software writes the pending bit back to 1. When the target acknowledged, the transmit flag is switched to the direction that was requested, so software knows whether it should send or receive next. A NACK leaves the transmit flag alone and shows up in the last-received-bit flag.

Top module: `i2c_addr_master`

## Requirements
- R1: After reset, master, transmit, busy, last-bit and interrupt outputs are 0, the pending output is 1, and neither line enable is asserted.
- R2: A control write with bits [7:4] = 1111 starts a transfer only when bus-busy is 0, the bit-count field (configuration bits [7:5]) is 000 and no transfer is in progress. On the next cycle master, transmit and pending read 1, and the block pulls SDA low with SCL released for one half period.
- R3: The half period is 4 << S system cycles, where S is configuration bits [2:0]. Each address clock consists of one half period with SCL pulled low followed by one half period with SCL released. SDA is pulled low for a 0 bit and released for a 1 bit, and it is stable while SCL is released.
- R4: The eight clocks carry the data-buffer register MSB first: address in bits [7:1], direction in bit 0 (0 = write, 1 = read). When configuration bit 4 (acknowledge enable) is 1, a ninth clock follows with SDA released. The SDA level on the last cycle of its high half is stored as the last-received bit.
- R5: At the falling SCL edge that ends the address phase, the interrupt output pulses high for exactly one cycle and the pending flag becomes 0 on that same cycle.
- R6: While master is 1 and pending is 0, SCL is pulled low. A control write with bit 4 set releases SCL on the following cycle and sets pending to 1.
- R7: If the target acknowledged (SDA low), the transmit flag becomes the inverse of the sent direction bit. On a NACK it keeps its value.
- R8: A start command is ignored while bus-busy is 1 or the bit-count field is non-zero. Neither line is pulled and the flags are unchanged.
- R9: With acknowledge enable 0, only eight clocks are issued, the interrupt follows the eighth, and the transmit and last-bit flags keep their values.
- R10: A control write with bits [7:4] = 0001 clears master and transmit and sets pending, which is the idle receiver setup.
- R11: Bus-busy is set when SDA falls while SCL is high and is cleared on the clock after SDA rises while SCL is high, both judged on the resolved lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 data buffer, 2 configuration |
| wr_data | input | 8 | Register write value |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| mst_o | output | 1 | Master mode flag |
| trx_o | output | 1 | Transmit direction flag |
| bb_o | output | 1 | Bus busy flag |
| pin_o | output | 1 | Pending flag (0 = waiting for service) |
| lrb_o | output | 1 | Last received bit |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench compares both line enables on every cycle against a waveform list that it builds from the address byte and the half period. An error of one cycle in the divider, a missed bit, or bits sent LSB first would therefore fail at the first cycle that differs. It runs a write that is acknowledged, a read that is acknowledged, a read that gets a NACK, and an address phase with acknowledge disabled. The NACK case catches a design that changes the transmit flag without an acknowledge. The case without acknowledge catches a ninth clock that should not be there and a last-bit value that gets overwritten. It also tries a start while the bus is busy and a start with a non-zero bit count, and it checks that SCL stays low for the whole service wait. A design that ignored bus-busy would start pulling lines, and one that let SCL go early would release the bus before software answered.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_LO,
    ST_HI,
    ST_ALO,
    ST_AHI,
    ST_HOLD
  } seq_st_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_DATA = 2'd1;
  localparam logic [1:0] REG_CFG  = 2'd2;

  // Half period of SCL in system cycles for a given divider select.
  function automatic int unsigned half_len(input int unsigned base, input int unsigned sel);
    return base << sel;
  endfunction

endpackage

// File: rtl/i2c_am_tick.sv
module i2c_am_tick #(
  parameter int BASE_HALF = 4,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import i2c_am_pkg::*;

  localparam int MAX_HALF = BASE_HALF << ((1 << SEL_W) - 1);
  localparam int CW       = $clog2(MAX_HALF + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;

  assign reload = CW'(half_len(BASE_HALF, int'(sel)) - 1);
  assign tick   = (cnt == '0) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (restart || cnt == '0)    cnt <= reload;
    else                              cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/i2c_am_busmon.sv
module i2c_am_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic bb,
  output logic start_seen,
  output logic stop_seen
);
  logic scl_q, sda_q;

  assign start_seen = sda_q && !sda_i && scl_q && scl_i;
  assign stop_seen  = !sda_q && sda_i && scl_q && scl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      bb    <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_seen)     bb <= 1'b1;
      else if (stop_seen) bb <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_am_seq.sv
module i2c_am_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       release_i,
  input  logic       ack_en,
  input  logic [7:0] addr_byte,
  input  logic       tick,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       fin_now,
  output logic       fin_ack,
  output logic       dir,
  output logic       idle,
  output logic       holding,
  output logic       xfer_hi
);
  import i2c_am_pkg::*;

  seq_st_t    st;
  logic [2:0] bitn;
  logic [7:0] shr;
  logic       data_ph;

  assign data_ph = (st == ST_LO) || (st == ST_HI);
  assign scl_oe  = (st == ST_LO) || (st == ST_ALO) || (st == ST_HOLD);
  assign sda_oe  = (st == ST_START) || (data_ph && !shr[bitn]);
  assign idle    = (st == ST_IDLE);
  assign holding = (st == ST_HOLD);
  assign xfer_hi = (st == ST_START) || (st == ST_HI) || (st == ST_AHI);
  assign dir     = shr[0];
  assign fin_ack = tick && (st == ST_AHI);
  assign fin_now = fin_ack || (tick && st == ST_HI && bitn == 3'd0 && !ack_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      bitn <= 3'd7;
      shr  <= 8'h00;
    end else begin
      unique case (st)
        ST_IDLE: if (go) begin
          st   <= ST_START;
          shr  <= addr_byte;
          bitn <= 3'd7;
        end
        ST_START: if (tick) st <= ST_LO;
        ST_LO:    if (tick) st <= ST_HI;
        ST_HI: if (tick) begin
          if (bitn == 3'd0) st <= ack_en ? ST_ALO : ST_HOLD;
          else begin
            bitn <= bitn - 3'd1;
            st   <= ST_LO;
          end
        end
        ST_ALO:  if (tick) st <= ST_AHI;
        ST_AHI:  if (tick) st <= ST_HOLD;
        ST_HOLD: if (release_i) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_addr_master.sv
module i2c_addr_master #(
  parameter int BASE_HALF = 4,
  parameter int SEL_W     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       mst_o,
  output logic       trx_o,
  output logic       bb_o,
  output logic       pin_o,
  output logic       lrb_o,
  output logic       irq_o
);
  import i2c_am_pkg::*;

  logic [7:0]       dbr;
  logic [2:0]       bc_q;
  logic             aen_q;
  logic [SEL_W-1:0] sck_q;

  logic wr_ctrl, start_go, slave_cfg, release_w;
  logic tick, fin_now, fin_ack, dir, seq_idle, seq_hold, xfer_hi;
  logic start_seen, stop_seen;
  logic [3:0] cmd;

  assign cmd       = wr_data[7:4];
  assign wr_ctrl   = wr_en && (wr_addr == REG_CTRL);
  assign start_go  = wr_ctrl && (cmd == 4'b1111) && !bb_o && seq_idle && (bc_q == 3'b000);
  assign slave_cfg = wr_ctrl && (cmd == 4'b0001);
  assign release_w = wr_ctrl && cmd[0] && seq_hold;

  i2c_am_tick #(.BASE_HALF(BASE_HALF), .SEL_W(SEL_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .restart(start_go), .sel(sck_q), .tick(tick)
  );

  i2c_am_busmon mon_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .bb(bb_o), .start_seen(start_seen), .stop_seen(stop_seen)
  );

  i2c_am_seq seq_i (
    .clk(clk), .rst_n(rst_n), .go(start_go), .release_i(release_w),
    .ack_en(aen_q), .addr_byte(dbr), .tick(tick),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .fin_now(fin_now), .fin_ack(fin_ack),
    .dir(dir), .idle(seq_idle), .holding(seq_hold), .xfer_hi(xfer_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbr   <= 8'h00;
      bc_q  <= 3'b000;
      aen_q <= 1'b0;
      sck_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == REG_DATA) dbr <= wr_data;
      if (wr_addr == REG_CFG) begin
        bc_q  <= wr_data[7:5];
        aen_q <= wr_data[4];
        sck_q <= wr_data[SEL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_o <= 1'b0;
      trx_o <= 1'b0;
      pin_o <= 1'b1;
      lrb_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= fin_now;
      if (start_go) begin
        mst_o <= 1'b1;
        trx_o <= 1'b1;
        pin_o <= 1'b1;
      end else if (fin_now) begin
        pin_o <= 1'b0;
        if (fin_ack) begin
          lrb_o <= sda_i;
          if (!sda_i) trx_o <= !dir;
        end
      end else begin
        if (slave_cfg) begin
          mst_o <= 1'b0;
          trx_o <= 1'b0;
        end
        if (slave_cfg || release_w) pin_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic irq,
  input logic pin,
  input logic mst,
  input logic bb,
  input logic start_go,
  input logic stop_seen,
  input logic xfer_hi
);
  // R6
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n) (mst && !pin) |-> scl_oe);
  // R5
  irq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> !pin);
  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  // R8
  start_free_chk: assert property (@(posedge clk) disable iff (!rst_n) start_go |-> !bb);
  // R11
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) stop_seen |=> !bb);
  // R3
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_hi && $past(xfer_hi)) |-> $stable(sda_oe));
endmodule

bind i2c_addr_master i2c_am_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq_o),
  .pin(pin_o), .mst(mst_o), .bb(bb_o), .start_go(start_go),
  .stop_seen(stop_seen), .xfer_hi(xfer_hi)
);

// File: tb/i2c_addr_master_tb.sv
module i2c_addr_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic tb_scl = 1'b1, tb_sda = 1'b1;
  logic scl_i, sda_i, scl_oe, sda_oe;
  logic mst_o, trx_o, bb_o, pin_o, lrb_o, irq_o;
  int nvec = 0, nerr = 0;
  bit done = 0;
  bit trx_m = 0, lrb_m = 0, mst_m = 0;

  always #10 clk = ~clk;

  assign scl_i = !scl_oe && tb_scl;
  assign sda_i = !sda_oe && tb_sda;

  i2c_addr_master dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .mst_o(mst_o), .trx_o(trx_o), .bb_o(bb_o), .pin_o(pin_o),
    .lrb_o(lrb_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic flags(input string req);
    chk({req, " mst"}, mst_o, mst_m);
    chk({req, " trx"}, trx_o, trx_m);
    chk({req, " lrb"}, lrb_o, lrb_m);
  endtask

  task automatic idle_window(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      chk({req, " lines"}, {scl_oe, sda_oe}, 2'b00);
      @(negedge clk);
    end
    chk({req, " pin"}, pin_o, 1'b1);
    flags(req);
  endtask

  task automatic bus_stop();
    tb_scl = 1'b0; @(negedge clk);
    tb_sda = 1'b0; @(negedge clk);
    tb_scl = 1'b1; @(negedge clk);
    tb_sda = 1'b1; @(negedge clk);
    chk("R11 busy cleared by stop", bb_o, 1'b0);
  endtask

  task automatic run_xfer(input logic [6:0] a, input bit dir, input bit aen,
                          input logic [2:0] sck, input bit slv_ack);
    int h;
    logic [7:0] byt;
    logic [1:0] q[$];
    h = 4 << sck;
    byt = {a, dir};
    q = {};
    for (int i = 0; i < h; i++) q.push_back(2'b01);
    for (int b = 7; b >= 0; b--) begin
      for (int i = 0; i < h; i++) q.push_back({1'b1, !byt[b]});
      for (int i = 0; i < h; i++) q.push_back({1'b0, !byt[b]});
    end
    if (aen) for (int i = 0; i < 2 * h; i++) q.push_back({i < h, 1'b0});
    wr(2'd2, {3'b000, aen, 1'b0, sck});
    wr(2'd1, byt);
    wr(2'd0, 8'hF0);
    mst_m = 1; trx_m = 1;
    chk("R2 master set", mst_o, 1'b1);
    chk("R2 pending set", pin_o, 1'b1);
    for (int k = 0; k < q.size(); k++) begin
      if (k > 0) @(negedge clk);
      if (aen && k == 17 * h) tb_sda = !slv_ack;
      if (k < h) chk("R2 start shape", {scl_oe, sda_oe}, q[k]);
      else if (k < 17 * h) chk("R3 address clocks", {scl_oe, sda_oe}, q[k]);
      else chk("R4 ninth clock", {scl_oe, sda_oe}, q[k]);
    end
    @(negedge clk);
    if (aen) begin
      lrb_m = !slv_ack;
      if (slv_ack) trx_m = !dir;
    end
    chk("R5 irq raised", irq_o, 1'b1);
    chk("R5 pending cleared", pin_o, 1'b0);
    chk("R6 scl held", scl_oe, 1'b1);
    chk("R11 busy after start", bb_o, 1'b1);
    flags(aen ? "R7" : "R9");
    @(negedge clk);
    chk("R5 irq single cycle", irq_o, 1'b0);
    tb_sda = 1'b1;
    for (int i = 0; i < 24; i++) begin
      chk("R6 stretch", scl_oe, 1'b1);
      @(negedge clk);
    end
    wr(2'd0, 8'h90);
    chk("R6 released", scl_oe, 1'b0);
    chk("R6 pending set", pin_o, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 lines", {scl_oe, sda_oe}, 2'b00);
    chk("R1 flags", {mst_o, trx_o, bb_o, pin_o, lrb_o, irq_o}, 6'b000100);
    // write, acknowledged
    run_xfer(7'h2D, 1'b0, 1'b1, 3'd0, 1'b1);
    // R8: bus still busy
    wr(2'd0, 8'hF0);
    idle_window("R8 busy", 12);
    bus_stop();
    // read, acknowledged, slower divider
    run_xfer(7'h33, 1'b1, 1'b1, 3'd1, 1'b1);
    bus_stop();
    // read, not acknowledged
    run_xfer(7'h7F, 1'b1, 1'b1, 3'd0, 1'b0);
    bus_stop();
    // R9 acknowledge disabled
    run_xfer(7'h01, 1'b0, 1'b0, 3'd0, 1'b1);
    bus_stop();
    // R8 non-zero bit count
    wr(2'd2, 8'h30);
    wr(2'd0, 8'hF0);
    idle_window("R8 bit count", 12);
    // R10 receiver setup
    wr(2'd0, 8'h10);
    mst_m = 0; trx_m = 0;
    chk("R10 pending", pin_o, 1'b1);
    flags("R10");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule